// File: doc/BRIEF.md
# Serial Byte Echo with Bitwise Inversion

This block takes asynchronous serial frames on one line and answers each one on a second line. Each frame has one low start bit, eight data bits sent least-significant first, one high stop bit and no parity. An idle line sits high. The incoming line is first passed through a two-stage synchronizer. A receiver then finds the start edge and confirms the start bit at its midpoint. It samples every following bit at mid-bit and rebuilds the byte.

When a frame ends with a proper high stop bit, the receiver raises a one-cycle strobe. That strobe starts the transmitter directly, and the transmitter sends the bitwise complement of the byte. There is no buffer between the receiver and the transmitter. A strobe that arrives while the transmitter is still sending is dropped. A frame whose stop bit reads low is discarded and reported as a one-cycle framing flag.

One parameter, the number of clock cycles per bit, sets the bit time for both directions. Its value is the system clock frequency divided by the baud rate, for example 868 at 100 MHz and 115200 baud.

Top module: `uart_echo_loop`

## Requirements
- R1: While reset is low and right after it is released, `ser_out` is 1, `tx_busy` is 0 and `frame_err` is 0.
- R2: An echoed frame on `ser_out` has a low start bit, then eight data bits with bit 0 first, then a high stop bit. Each bit lasts exactly CLKS_PER_BIT cycles. For a lone frame, `tx_busy` stays high for exactly 10*CLKS_PER_BIT cycles.
- R3: Each correctly framed byte B received on `ser_in` is sent back once on `ser_out` as ~B (0xA5 gives 0x5A, 0x55 gives 0xAA).
- R4: A low pulse on `ser_in` that has gone high again by the start-bit midpoint is treated as a glitch. It causes no echo, no framing flag and no transmitter activity.
- R5: A frame whose stop bit is sampled low causes no echo and exactly one framing-error pulse, one cycle wide. The next valid frame is echoed normally.
- R6: Frames sent back to back, with each start edge directly after the previous stop bit, are all received and echoed, in order.
- R7: A byte strobe that arrives while the transmitter is busy, before the last cycle of its stop bit, is ignored. The frame being sent is not disturbed, and `tx_busy` rises the cycle after an accepted strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_in | input | 1 | Asynchronous serial receive line, idles high |
| ser_out | output | 1 | Serial transmit line carrying the inverted echo |
| tx_busy | output | 1 | High while the transmitter is sending a frame |
| frame_err | output | 1 | One-cycle pulse when a received stop bit reads low |

## Verification
The assertions assume that whoever drives `ser_in` uses the same bit time as the block, to within a few cycles. The receiver's counters and its single strobe per frame rely on that. The stimulus holds every bit for exactly CLKS_PER_BIT cycles and changes the line away from the sampling clock edge. It departs from whole bit lengths only on purpose: a short glitch, and one stop bit trimmed to just over half a bit so that the next frame's strobe lands while the transmitter is busy. The properties also take for granted that the input can still be high at the start-bit midpoint. The glitch test exercises that path.

// File: rtl/uart_echo_pkg.sv
package uart_echo_pkg;

  typedef enum logic [1:0] {
    RX_IDLE, RX_START, RX_DATA, RX_STOP
  } rx_state_t;

  typedef enum logic [1:0] {
    TX_IDLE, TX_START, TX_DATA, TX_STOP
  } tx_state_t;

  // cycles from start-edge detection to the start-bit midpoint sample
  function automatic int half_bit(input int cpb);
    return (cpb > 1) ? cpb / 2 : 1;
  endfunction

  // counter width able to hold the value n
  function automatic int cnt_width(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

  // cycles a lone echoed frame occupies on the output
  function automatic int frame_cycles(input int cpb, input int dw);
    return cpb * (dw + 2);
  endfunction

endpackage

// File: rtl/echo_sync.sv
module echo_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], d_i};
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/echo_rx.sv
module echo_rx
  import uart_echo_pkg::*;
#(
  parameter int CPB = 868,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_i,
  output logic [DW-1:0] byte_o,
  output logic          valid_o,
  output logic          ferr_o
);
  localparam int HALF = half_bit(CPB);
  localparam int CW   = cnt_width(CPB);
  localparam int IW   = $clog2(DW);

  rx_state_t      state;
  logic [CW-1:0]  cnt;
  logic [IW-1:0]  idx;
  logic [DW-1:0]  shreg;
  logic           line_q;

  wire start_edge = line_q & ~line_i;
  wire half_tick  = (cnt == CW'(HALF - 1));
  wire bit_tick   = (cnt == CW'(CPB - 1));
  wire last_bit   = (idx == IW'(DW - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= RX_IDLE;
      cnt     <= '0;
      idx     <= '0;
      shreg   <= '0;
      byte_o  <= '0;
      valid_o <= 1'b0;
      ferr_o  <= 1'b0;
      line_q  <= 1'b1;
    end else begin
      line_q  <= line_i;
      valid_o <= 1'b0;
      ferr_o  <= 1'b0;
      case (state)
        RX_IDLE: begin
          cnt <= '0;
          if (start_edge) state <= RX_START;
        end
        RX_START: begin
          if (half_tick) begin
            cnt   <= '0;
            idx   <= '0;
            state <= line_i ? RX_IDLE : RX_DATA;
          end else cnt <= cnt + 1'b1;
        end
        RX_DATA: begin
          if (bit_tick) begin
            cnt   <= '0;
            shreg <= {line_i, shreg[DW-1:1]};
            if (last_bit) state <= RX_STOP;
            else          idx   <= idx + 1'b1;
          end else cnt <= cnt + 1'b1;
        end
        RX_STOP: begin
          if (bit_tick) begin
            cnt   <= '0;
            state <= RX_IDLE;
            if (line_i) begin
              valid_o <= 1'b1;
              byte_o  <= shreg;
            end else begin
              ferr_o  <= 1'b1;
            end
          end else cnt <= cnt + 1'b1;
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

  // R5
  rx_flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({valid_o, ferr_o}));

  // R5
  rx_ferr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ferr_o |=> !ferr_o);

  // R3
  rx_valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  // R2
  rx_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CW'(CPB));
endmodule

// File: rtl/echo_tx.sv
module echo_tx
  import uart_echo_pkg::*;
#(
  parameter int CPB = 868,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [DW-1:0] data_i,
  output logic          line_o,
  output logic          busy_o
);
  localparam int CW = cnt_width(CPB);
  localparam int IW = $clog2(DW);

  tx_state_t      state;
  logic [CW-1:0]  cnt;
  logic [IW-1:0]  idx;
  logic [DW-1:0]  shreg;

  wire bit_end = (state != TX_IDLE) && (cnt == CW'(CPB - 1));
  wire load    = start_i && ((state == TX_IDLE) || ((state == TX_STOP) && bit_end));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= TX_IDLE;
      cnt    <= '0;
      idx    <= '0;
      shreg  <= '0;
      line_o <= 1'b1;
    end else if (load) begin
      shreg  <= data_i;
      state  <= TX_START;
      cnt    <= '0;
      line_o <= 1'b0;
    end else begin
      case (state)
        TX_IDLE: begin
          cnt    <= '0;
          line_o <= 1'b1;
        end
        TX_START: begin
          if (bit_end) begin
            cnt    <= '0;
            idx    <= '0;
            state  <= TX_DATA;
            line_o <= shreg[0];
            shreg  <= shreg >> 1;
          end else cnt <= cnt + 1'b1;
        end
        TX_DATA: begin
          if (bit_end) begin
            cnt <= '0;
            if (idx == IW'(DW - 1)) begin
              state  <= TX_STOP;
              line_o <= 1'b1;
            end else begin
              idx    <= idx + 1'b1;
              line_o <= shreg[0];
              shreg  <= shreg >> 1;
            end
          end else cnt <= cnt + 1'b1;
        end
        TX_STOP: begin
          if (bit_end) begin
            cnt   <= '0;
            state <= TX_IDLE;
          end else cnt <= cnt + 1'b1;
        end
        default: state <= TX_IDLE;
      endcase
    end
  end

  assign busy_o = (state != TX_IDLE);

  // R2
  tx_start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> !line_o);

  // R1
  tx_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> line_o);

  // R2
  tx_edge_on_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(line_o) |-> $past(bit_end || load));

  // R2
  tx_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CW'(CPB));
endmodule

// File: rtl/uart_echo_loop.sv
module uart_echo_loop #(
  parameter int CLKS_PER_BIT = 868,
  parameter int DATA_W       = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ser_in,
  output logic ser_out,
  output logic tx_busy,
  output logic frame_err
);
  logic              line_sync;
  logic [DATA_W-1:0] rx_byte;
  logic              rx_valid;
  logic [DATA_W-1:0] tx_byte;

  echo_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(ser_in), .q_o(line_sync)
  );

  echo_rx #(.CPB(CLKS_PER_BIT), .DW(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .line_i(line_sync),
    .byte_o(rx_byte), .valid_o(rx_valid), .ferr_o(frame_err)
  );

  assign tx_byte = ~rx_byte;

  echo_tx #(.CPB(CLKS_PER_BIT), .DW(DATA_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .start_i(rx_valid), .data_i(tx_byte),
    .line_o(ser_out), .busy_o(tx_busy)
  );

  // R7
  echo_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !tx_busy) |=> tx_busy);

  // R4
  echo_idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_busy && !rx_valid) |=> !tx_busy);
endmodule

// File: tb/sim_uart_echo_loop.sv
module sim_uart_echo_loop;
  localparam int CPB = 16;
  localparam int DW  = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic ser_in;
  logic ser_out, tx_busy, frame_err;

  uart_echo_loop #(.CLKS_PER_BIT(CPB), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in),
    .ser_out(ser_out), .tx_busy(tx_busy), .frame_err(frame_err)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int echoes = 0;
  int ferr_pulses = 0, ferr_w = 0, ferr_max_w = 0;
  int busy_cnt = 0, busy_len_last = 0;
  string cur_req = "R3";
  logic [DW-1:0] exp_q[$];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // driver: one frame, caller sits on a falling clock edge
  task automatic send(input logic [DW-1:0] b, input int stop_len,
                      input logic stop_lvl, input bit expect_echo);
    if (expect_echo) exp_q.push_back(~b);
    ser_in = 1'b0;
    repeat (CPB) @(negedge clk);
    for (int i = 0; i < DW; i++) begin
      ser_in = b[i];
      repeat (CPB) @(negedge clk);
    end
    ser_in = stop_lvl;
    repeat (stop_len) @(negedge clk);
  endtask

  // monitor: decode echoed frames mid-bit and score them
  initial begin
    logic prev = 1'b1;
    forever begin
      @(negedge clk);
      if (rst_n && prev && !ser_out) begin
        logic [DW-1:0] got;
        logic [DW-1:0] want;
        repeat (CPB / 2) @(negedge clk);
        check(ser_out == 1'b0, "R2", "start bit level", ser_out, 0);
        for (int i = 0; i < DW; i++) begin
          repeat (CPB) @(negedge clk);
          got[i] = ser_out;
        end
        repeat (CPB) @(negedge clk);
        check(ser_out == 1'b1, "R2", "stop bit level", ser_out, 1);
        echoes++;
        if (exp_q.size() == 0) begin
          check(1'b0, cur_req, "unexpected echo", got, -1);
        end else begin
          want = exp_q.pop_front();
          check(got == want, cur_req, "echoed byte", got, want);
        end
      end
      prev = ser_out;
    end
  end

  // pulse-width monitors for busy and framing flag
  always @(negedge clk) begin
    if (tx_busy) busy_cnt++;
    else if (busy_cnt > 0) begin
      busy_len_last = busy_cnt;
      busy_cnt = 0;
    end
    if (frame_err) ferr_w++;
    else if (ferr_w > 0) begin
      ferr_pulses++;
      if (ferr_w > ferr_max_w) ferr_max_w = ferr_w;
      ferr_w = 0;
    end
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual=expired expected=finished");
    summary();
  end

  initial begin
    int base;
    ser_in = 1'b1;
    rst_n  = 1'b0;
    repeat (5) @(negedge clk);
    // R1 during reset
    check(ser_out == 1'b1, "R1", "ser_out in reset", ser_out, 1);
    check(tx_busy == 1'b0, "R1", "tx_busy in reset", tx_busy, 0);
    check(frame_err == 1'b0, "R1", "frame_err in reset", frame_err, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(ser_out == 1'b1 && !tx_busy, "R1", "idle after release", ser_out, 1);

    // R3 / R2: lone frames
    cur_req = "R3";
    send(8'hA5, CPB, 1'b1, 1'b1);
    repeat (12 * CPB) @(negedge clk);
    check(busy_len_last == CPB * (DW + 2), "R2", "busy length", busy_len_last, CPB * (DW + 2));
    check(echoes == 1, "R3", "echo count", echoes, 1);
    send(8'h3C, CPB, 1'b1, 1'b1);
    repeat (12 * CPB) @(negedge clk);
    check(echoes == 2, "R3", "echo count", echoes, 2);

    // R6: back-to-back frames
    cur_req = "R6";
    send(8'h55, CPB, 1'b1, 1'b1);
    send(8'h00, CPB, 1'b1, 1'b1);
    send(8'hFF, CPB, 1'b1, 1'b1);
    send(8'hC3, CPB, 1'b1, 1'b1);
    repeat (12 * CPB) @(negedge clk);
    check(echoes == 6, "R6", "echo count", echoes, 6);
    check(exp_q.size() == 0, "R6", "pending echoes", exp_q.size(), 0);

    // R4: glitch shorter than half a bit
    cur_req = "R4";
    base = echoes;
    ser_in = 1'b0;
    repeat (3) @(negedge clk);
    ser_in = 1'b1;
    repeat (CPB / 2) @(negedge clk);
    check(tx_busy == 1'b0, "R4", "busy after glitch", tx_busy, 0);
    repeat (12 * CPB) @(negedge clk);
    check(echoes == base, "R4", "echo count", echoes, base);
    check(ferr_pulses == 0, "R4", "framing pulses", ferr_pulses, 0);

    // R5: low stop bit
    cur_req = "R5";
    base = echoes;
    send(8'h5A, CPB, 1'b0, 1'b0);
    ser_in = 1'b1;
    repeat (12 * CPB) @(negedge clk);
    check(ferr_pulses == 1, "R5", "framing pulses", ferr_pulses, 1);
    check(ferr_max_w == 1, "R5", "framing pulse width", ferr_max_w, 1);
    check(echoes == base, "R5", "echo count", echoes, base);
    send(8'h0F, CPB, 1'b1, 1'b1);
    repeat (12 * CPB) @(negedge clk);
    check(echoes == base + 1, "R5", "echo after error", echoes, base + 1);

    // R7: second strobe lands while transmitter is busy
    cur_req = "R7";
    base = echoes;
    send(8'h81, CPB / 2 + 6, 1'b1, 1'b1);
    send(8'h42, CPB, 1'b1, 1'b0);
    repeat (12 * CPB) @(negedge clk);
    check(echoes == base + 1, "R7", "echo count", echoes, base + 1);
    check(busy_len_last == CPB * (DW + 2), "R7", "busy length", busy_len_last, CPB * (DW + 2));
    send(8'h96, CPB, 1'b1, 1'b1);
    repeat (12 * CPB) @(negedge clk);
    check(echoes == base + 2, "R7", "echo after drop", echoes, base + 2);

    check(exp_q.size() == 0, "R3", "pending echoes at end", exp_q.size(), 0);
    summary();
  end
endmodule